// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port shared memory and watches the enable and address of each port. When both ports are enabled on the same address it decides which port arrived first, lets that port carry on and pulls the other port's active-low busy line low. The losing port's write strobe is suppressed, so a blocked write never reaches the array. When two ports land on one address in the same cycle, a fixed priority set by a parameter picks the winner.

The block is synchronous to one clock and samples both ports on its rising edge. In master mode it drives the two busy outputs. In slave mode it stops arbitrating at its outputs and releases them high; the busy inputs, driven by a master elsewhere, then decide which writes go through. Each port gets a gated write strobe and an inhibit flag that the memory array can use directly.

Top module: `dp_collide_arb`

## Requirements
- R1: While reset is asserted (rst_n low), both busy outputs are high, both inhibit outputs are low, and the state of both ports counts as disabled.
- R2: In master mode, if in a sampled cycle the ports are not both enabled on equal addresses, both busy outputs are high after that clock edge.
- R3: In master mode, when the right port becomes enabled on the address that the left port already held unchanged and enabled in the previous sampled cycle, the right busy output goes low on the next edge and the left busy output stays high.
- R4: In master mode, the mirror case of R3: when the left port joins an address the right port already held, the left busy output goes low on the next edge and the right busy output stays high.
- R5: When both ports change (enable or address) in the same sampled cycle and then match, the port selected by parameter LEFT_WINS wins: with LEFT_WINS=1 (the default) the right busy goes low, otherwise the left busy goes low.
- R6: The two busy outputs are never low in the same cycle.
- R7: A port's write strobe (x_wr_go) is high exactly when that port is enabled, its write enable is high and its grant is present. In master mode the grant is its own busy output high, and the inhibit output is the inverse of the grant.
- R8: A busy output returns high on the first edge after the match ends, whether by an address change or by either enable going low.
- R9: While the match persists with neither port changing enable or address, the winner and loser stay as first decided, whatever the write enables do.
- R10: In slave mode (slave_mode high) both busy outputs are high, and a low busy input on a port inhibits that port's writes; a high busy input lets them through.
- R11: In master mode the busy inputs have no effect on busy, inhibit or write strobe outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; ports sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | High: consume busy inputs; low: arbitrate and drive busy |
| l_en | input | 1 | Left port enable |
| l_addr | input | AW | Left port address |
| l_we | input | 1 | Left port write enable |
| r_en | input | 1 | Right port enable |
| r_addr | input | AW | Right port address |
| r_we | input | 1 | Right port write enable |
| l_busy_in_n | input | 1 | Left busy from an external master (slave mode) |
| r_busy_in_n | input | 1 | Right busy from an external master (slave mode) |
| l_busy_out_n | output | 1 | Left busy, active low |
| r_busy_out_n | output | 1 | Right busy, active low |
| l_inhibit | output | 1 | Left writes blocked |
| r_inhibit | output | 1 | Right writes blocked |
| l_wr_go | output | 1 | Left write strobe to the array |
| r_wr_go | output | 1 | Right write strobe to the array |

## Verification
A stale copy of a port's previous enable or address would misjudge arrival order, and the busy line would drop on the wrong side on the very edge after a collision starts. A stuck winner would show as busy staying low one edge past the end of a match, or as a blocked port's write landing in the bench's shadow memory. Because the reference model is compared every cycle, any such fault shows within one clock of the stimulus that exposes it. The final scan of the shadow memory also catches blocked writes that were not caught at the time.

// File: rtl/dp_collide_arb.sv
module dp_collide_arb #(
  parameter int AW        = 14,
  parameter bit LEFT_WINS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_we,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_we,
  input  logic          l_busy_in_n,
  input  logic          r_busy_in_n,
  output logic          l_busy_out_n,
  output logic          r_busy_out_n,
  output logic          l_inhibit,
  output logic          r_inhibit,
  output logic          l_wr_go,
  output logic          r_wr_go
);
  localparam logic [1:0] OWN_NONE = 2'd0;
  localparam logic [1:0] OWN_L    = 2'd1;
  localparam logic [1:0] OWN_R    = 2'd2;
  localparam logic [1:0] OWN_TIE  = LEFT_WINS ? OWN_L : OWN_R;

  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          l_en_q, r_en_q;
  logic [1:0]    owner_q, owner_d;
  logic          l_busy_q, r_busy_q;
  logic          l_grant, r_grant;

  wire hit     = l_en & r_en & (l_addr == r_addr);
  wire l_moved = (l_en != l_en_q) | (l_addr != l_addr_q);
  wire r_moved = (r_en != r_en_q) | (r_addr != r_addr_q);

  always_comb begin
    owner_d = owner_q;
    if (!hit)
      owner_d = OWN_NONE;
    else if (owner_q == OWN_NONE || l_moved || r_moved) begin
      if (l_moved && !r_moved)      owner_d = OWN_R;
      else if (r_moved && !l_moved) owner_d = OWN_L;
      else                          owner_d = OWN_TIE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_addr_q <= '0;
      r_addr_q <= '0;
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      owner_q  <= OWN_NONE;
      l_busy_q <= 1'b1;
      r_busy_q <= 1'b1;
    end else begin
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      owner_q  <= owner_d;
      l_busy_q <= !(hit && owner_d == OWN_R);
      r_busy_q <= !(hit && owner_d == OWN_L);
    end
  end

  assign l_busy_out_n = slave_mode | l_busy_q;
  assign r_busy_out_n = slave_mode | r_busy_q;
  assign l_grant      = slave_mode ? l_busy_in_n : l_busy_q;
  assign r_grant      = slave_mode ? r_busy_in_n : r_busy_q;
  assign l_inhibit    = ~l_grant;
  assign r_inhibit    = ~r_grant;
  assign l_wr_go      = l_en & l_we & l_grant;
  assign r_wr_go      = r_en & r_we & r_grant;
endmodule

module dp_collide_arb_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_mode,
  input logic          l_en,
  input logic [AW-1:0] l_addr,
  input logic          r_en,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_in_n,
  input logic          r_busy_in_n,
  input logic          l_busy_out_n,
  input logic          r_busy_out_n,
  input logic          l_wr_go,
  input logic          r_wr_go
);
  a_r6_never_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_out_n && !r_busy_out_n));

  a_r2_release_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && r_en && l_addr == r_addr) |=> (l_busy_out_n && r_busy_out_n));

  a_r7_left_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !l_busy_out_n) |-> !l_wr_go);

  a_r7_right_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !r_busy_out_n) |-> !r_wr_go);

  a_r10_slave_outputs_high: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (l_busy_out_n && r_busy_out_n));

  a_r10_slave_input_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && (!l_busy_in_n || !r_busy_in_n)) |->
      ((l_busy_in_n || !l_wr_go) && (r_busy_in_n || !r_wr_go)));
endmodule

bind dp_collide_arb dp_collide_arb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
  .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
  .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
  .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
  .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
);

// File: tb/tb_dp_collide_arb.sv
module tb_dp_collide_arb;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic l_en = 0, r_en = 0, l_we = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in_n = 1, r_busy_in_n = 1;
  logic l_busy_out_n, r_busy_out_n, l_inhibit, r_inhibit, l_wr_go, r_wr_go;

  always #10 clk = ~clk;

  dp_collide_arb #(.AW(AW), .LEFT_WINS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_en(l_en), .l_addr(l_addr), .l_we(l_we),
    .r_en(r_en), .r_addr(r_addr), .r_we(r_we),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
    .l_inhibit(l_inhibit), .r_inhibit(r_inhibit),
    .l_wr_go(l_wr_go), .r_wr_go(r_wr_go));

  int checks = 0;
  int errors = 0;

  // behavioural reference: 0 none, 1 left holds, 2 right holds
  int  m_owner = 0;
  bit  m_bl = 1, m_br = 1;
  bit  p_le = 0, p_re = 0;
  int  p_la = 0, p_ra = 0;
  int  exp_mem[int];
  int  shd_mem[int];
  int  wdata = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_owner = 0; m_bl = 1; m_br = 1;
      p_le = 0; p_re = 0; p_la = 0; p_ra = 0;
    end else begin
      bit match, lc, rc, gl, gr;
      gl = slave_mode ? l_busy_in_n : m_bl;
      gr = slave_mode ? r_busy_in_n : m_br;
      if (l_en && l_we && gl) exp_mem[int'(l_addr)] = wdata;
      if (r_en && r_we && gr) exp_mem[int'(r_addr)] = wdata + 1;
      if (l_wr_go) shd_mem[int'(l_addr)] = wdata;
      if (r_wr_go) shd_mem[int'(r_addr)] = wdata + 1;
      wdata = wdata + 2;
      match = l_en && r_en && (l_addr == r_addr);
      lc = (l_en != p_le) || (int'(l_addr) != p_la);
      rc = (r_en != p_re) || (int'(r_addr) != p_ra);
      if (!match) m_owner = 0;
      else if (m_owner == 0 || lc || rc) begin
        if (lc && !rc) m_owner = 2;
        else if (rc && !lc) m_owner = 1;
        else m_owner = 1;
      end
      m_bl = !(match && m_owner == 2);
      m_br = !(match && m_owner == 1);
      p_le = l_en; p_re = r_en; p_la = int'(l_addr); p_ra = int'(r_addr);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit gl, gr;
    gl = slave_mode ? l_busy_in_n : m_bl;
    gr = slave_mode ? r_busy_in_n : m_br;
    chk(tag, "l_busy_out_n", l_busy_out_n, slave_mode ? 1 : m_bl);
    chk(tag, "r_busy_out_n", r_busy_out_n, slave_mode ? 1 : m_br);
    chk(tag, "l_inhibit", l_inhibit, !gl);
    chk(tag, "r_inhibit", r_inhibit, !gr);
    chk(tag, "l_wr_go", l_wr_go, l_en && l_we && gl);
    chk(tag, "r_wr_go", r_wr_go, r_en && r_we && gr);
    chk("R6", "busy pair not both low", (!l_busy_out_n && !r_busy_out_n), 0);
  endtask

  task automatic step(input bit le, input int la, input bit lw,
                      input bit re, input int ra, input bit rw, input string tag);
    @(negedge clk);
    l_en = le; l_addr = AW'(la); l_we = lw;
    r_en = re; r_addr = AW'(ra); r_we = rw;
    #5;
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R1: reset state
    chk("R1", "l_busy_out_n", l_busy_out_n, 1);
    chk("R1", "r_busy_out_n", r_busy_out_n, 1);
    chk("R1", "l_inhibit", l_inhibit, 0);
    chk("R1", "r_inhibit", r_inhibit, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: distinct addresses, both write freely
    repeat (3) step(1, 5, 1, 1, 9, 1, "R2");
    step(1, 5, 1, 0, 5, 1, "R2");
    step(1, 5, 1, 0, 5, 1, "R2");

    // R3: left holds 3, right joins; right loses
    step(1, 3, 0, 0, 0, 0, "R3");
    step(1, 3, 0, 0, 0, 0, "R3");
    step(1, 3, 1, 1, 3, 1, "R3");
    step(1, 3, 0, 1, 3, 1, "R3");
    chk("R3", "r_busy_out_n after join", r_busy_out_n, 0);
    chk("R3", "l_busy_out_n after join", l_busy_out_n, 1);
    chk("R7", "r_wr_go while busy", r_wr_go, 0);
    // R9: hold while stable, write enables toggle
    step(1, 3, 1, 1, 3, 0, "R9");
    step(1, 3, 0, 1, 3, 1, "R9");
    chk("R9", "r_busy_out_n held", r_busy_out_n, 0);
    // R11: busy inputs ignored in master mode
    l_busy_in_n = 0; r_busy_in_n = 0;
    step(1, 3, 1, 1, 3, 1, "R11");
    chk("R11", "l_wr_go with busy input low", l_wr_go, 1);
    l_busy_in_n = 1; r_busy_in_n = 1;
    // R8: right moves away; release next edge
    step(1, 3, 1, 1, 4, 1, "R8");
    chk("R8", "r_busy_out_n still low on move cycle", r_busy_out_n, 0);
    step(1, 3, 1, 1, 4, 1, "R8");
    chk("R8", "r_busy_out_n released", r_busy_out_n, 1);

    // R4: right holds 7, left joins; left loses
    step(0, 0, 0, 1, 7, 0, "R4");
    step(0, 0, 0, 1, 7, 0, "R4");
    step(1, 7, 1, 1, 7, 1, "R4");
    step(1, 7, 1, 1, 7, 1, "R4");
    chk("R4", "l_busy_out_n after join", l_busy_out_n, 0);
    chk("R4", "r_busy_out_n after join", r_busy_out_n, 1);
    // R8: enable drop releases
    step(1, 7, 1, 0, 7, 0, "R8");
    step(1, 7, 1, 0, 7, 0, "R8");
    chk("R8", "l_busy_out_n after enable drop", l_busy_out_n, 1);

    // R5: simultaneous arrival, left wins by default
    step(1, 12, 1, 1, 12, 1, "R5");
    step(1, 12, 1, 1, 12, 1, "R5");
    chk("R5", "r_busy_out_n on tie", r_busy_out_n, 0);
    chk("R5", "l_busy_out_n on tie", l_busy_out_n, 1);
    step(1, 13, 1, 1, 13, 1, "R5");
    step(1, 13, 1, 1, 13, 1, "R5");
    chk("R5", "r_busy_out_n on moved tie", r_busy_out_n, 0);
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");

    // R10: slave mode
    slave_mode = 1'b1;
    l_busy_in_n = 0; r_busy_in_n = 1;
    step(1, 20, 1, 1, 21, 1, "R10");
    chk("R10", "l_wr_go with busy input low", l_wr_go, 0);
    chk("R10", "r_wr_go with busy input high", r_wr_go, 1);
    l_busy_in_n = 1; r_busy_in_n = 0;
    step(1, 22, 1, 1, 22, 1, "R10");
    step(1, 22, 1, 1, 22, 1, "R10");
    chk("R10", "l_busy_out_n in slave", l_busy_out_n, 1);
    chk("R10", "r_busy_out_n in slave", r_busy_out_n, 1);
    chk("R10", "r_inhibit with busy input low", r_inhibit, 1);
    l_busy_in_n = 1; r_busy_in_n = 1;
    slave_mode = 1'b0;
    step(0, 0, 0, 0, 0, 0, "R2");

    // R6, R7: mixed traffic over a tiny address range
    for (int i = 0; i < 3000; i++) begin
      if ((i % 500) == 250) slave_mode = ~slave_mode;
      l_busy_in_n = ($urandom % 4) != 0;
      r_busy_in_n = ($urandom % 4) != 0;
      step(($urandom % 4) != 0, $urandom % 3, $urandom % 2,
           ($urandom % 4) != 0, $urandom % 3, $urandom % 2, "R7");
    end
    slave_mode = 1'b0;

    // R7: blocked writes never reached the shadow memory
    foreach (exp_mem[k]) begin
      chk("R7", "shadow word present", shd_mem.exists(k), 1);
      if (shd_mem.exists(k)) chk("R7", "shadow word value", shd_mem[k], exp_mem[k]);
    end
    chk("R7", "shadow size", shd_mem.size(), exp_mem.size());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule